// File: doc/BRIEF.md
# Embedded video sync extractor

This block watches an 8-bit parallel video stream on the pixel clock and picks out the four-byte timing reference codes embedded in it: three bytes FFh, 00h, 00h followed by a status byte. Each status byte carries a horizontal and a vertical blanking flag, a field flag, and four protection bits. The block checks the protection bits, tracks whether the stream is in line or frame blanking, and checks that every blanking byte belongs to the alternating 80h/10h fill run. The stream may carry RGB565 or YCbCr 4:2:2 byte-multiplexed pixels in either byte order, as long as the pixel data never contains the three-byte FFh 00h 00h prefix.

From the recovered code positions it rebuilds horizontal and vertical sync pulses, each with a selectable polarity. It measures line length, blanking length and the number of active and blanking lines per frame, and compares them with programmed porch, sync-width and active-size values. Code, fill, line-timing and frame-timing faults each set a sticky flag that a write-one-to-clear input resets. A zero sync width or active size is reported as a configuration fault.

Top module: `video_sync_extract`

## Requirements
- R1: A code is recognised when FFh, 00h, 00h and a status byte arrive on four consecutive clocks. The status byte is laid out as bit7 = 1, bit6 = F, bit5 = V, bit4 = H, bits 3..0 = P3..P0. A good code with H = 1 starts line blanking, H = 0 ends it, and V gives the frame-blanking state. F has no effect on any output.
- R2: The expected protection bits are P3 = V^H, P2 = F^H, P1 = F^V and P0 = F^V^H. A status byte with a mismatch or with bit7 = 0 sets err_o[0]. Such a code is discarded and leaves the blanking state unchanged; it is never corrected.
- R3: While in line or frame blanking, the bytes after each code must alternate 80h, 10h, 80h, ... starting with 80h. Any other byte, or a broken FFh 00h 00h prefix, sets err_o[1].
- R4: Outside both blanking states, arbitrary pixel bytes never set err_o[1].
- R5: After the first H = 1 code, each later H = 1 code must arrive hfp+hsw+hbp+hact+8 clocks after the previous one, and each H = 0 code must arrive hfp+hsw+hbp+4 clocks after the last H = 1 code. Otherwise err_o[2] is set.
- R6: The V bit is sampled at H = 1 codes. From the second V change on, a run of V = 0 lines must be vact lines long and a run of V = 1 lines must be vfp+vsw+vbp lines long. Otherwise err_o[3] is set.
- R7: The horizontal sync is active while fill bytes hfp+1 through hfp+hsw after an H = 1 code are on the input. hs_o is high when active if hs_pol_i = 1, and low when active if hs_pol_i = 0.
- R8: Blanking lines are numbered from 0 at the H = 1 code where V rises. The vertical sync is active from the start of line vfp through the end of line vfp+vsw-1. Its polarity follows vs_pol_i in the same way as R7.
- R9: cfg_err_o is high exactly when hsw_i, hact_i, vsw_i or vact_i is zero. Zero porches are legal.
- R10: Each err_o bit stays set until a cycle with the same clr_i bit at 1. Clear bits for other flags leave it untouched.
- R11: Reset clears all flags, returns the code search to idle, forgets line and frame lock, and makes both syncs inactive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Pixel clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| data_i | input | 8 | Video byte stream |
| hs_pol_i | input | 1 | 1: hs_o active high |
| vs_pol_i | input | 1 | 1: vs_o active high |
| hfp_i | input | CW | Horizontal front porch, clocks |
| hsw_i | input | CW | Horizontal sync width, clocks |
| hbp_i | input | CW | Horizontal back porch, clocks |
| hact_i | input | CW | Active pixel bytes per line |
| vfp_i | input | CW | Vertical front porch, lines |
| vsw_i | input | CW | Vertical sync width, lines |
| vbp_i | input | CW | Vertical back porch, lines |
| vact_i | input | CW | Active lines per frame |
| clr_i | input | 4 | Write-one-to-clear for err_o |
| hs_o | output | 1 | Horizontal sync |
| vs_o | output | 1 | Vertical sync |
| err_o | output | 4 | Sticky flags: 0 code, 1 fill, 2 line timing, 3 frame timing |
| cfg_err_o | output | 1 | Zero sync width or active size |

## Verification
The hardest fault to reach is a frame-length mismatch. The frame check only arms after one V change, and a wrong active-line count only shows up at the H = 1 code that opens the next frame. The bench therefore sends clean frames to gain lock, then a frame with one extra active line, then a clean frame, and only then reads err_o[3]. Corrupt codes are placed in active-line slots of the same length, so that they disturb neither line timing nor fill checking. Sync outputs are compared on every blanking and pixel byte across all four polarity settings.

// File: rtl/vse_pkg.sv
package vse_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_FF, ST_Z1, ST_Z2} det_st_e;

  localparam logic [7:0] FILL_EVEN = 8'h80;
  localparam logic [7:0] FILL_ODD  = 8'h10;

  localparam int ERR_CODE = 0;
  localparam int ERR_FILL = 1;
  localparam int ERR_HTIM = 2;
  localparam int ERR_VTIM = 3;
  localparam int N_ERR    = 4;

  function automatic logic [3:0] prot_calc(input logic f, input logic v, input logic h);
    return {v ^ h, f ^ h, f ^ v, f ^ v ^ h};
  endfunction
endpackage

// File: rtl/vse_code_det.sv
module vse_code_det
  import vse_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [7:0] data_i,
  output logic       code_stb_o,
  output logic       code_h_o,
  output logic       code_v_o,
  output logic       code_err_o,
  output logic       fill_err_o
);
  det_st_e    st_q, st_d;
  logic       phase_q, phase_d;
  logic       hbl_q, vbl_q;
  logic       is_ff, is_00, xy_ok, in_blank;
  logic [7:0] exp_fill;

  always_comb begin
    is_ff    = (data_i == 8'hFF);
    is_00    = (data_i == 8'h00);
    xy_ok    = data_i[7] && (data_i[3:0] == prot_calc(data_i[6], data_i[5], data_i[4]));
    in_blank = hbl_q | vbl_q;
    exp_fill = phase_q ? FILL_ODD : FILL_EVEN;
    st_d       = ST_IDLE;
    phase_d    = phase_q;
    fill_err_o = 1'b0;
    case (st_q)
      ST_IDLE: begin
        if (is_ff) st_d = ST_FF;
        else if (in_blank) begin
          fill_err_o = (data_i != exp_fill);
          phase_d    = !phase_q;
        end
      end
      ST_FF, ST_Z1: begin
        if (is_00) st_d = (st_q == ST_FF) ? ST_Z1 : ST_Z2;
        else begin
          fill_err_o = in_blank;  // broken prefix inside blanking
          st_d       = is_ff ? ST_FF : ST_IDLE;
        end
      end
      ST_Z2:   phase_d = 1'b0;
      default: st_d = ST_IDLE;
    endcase
  end

  assign code_stb_o = (st_q == ST_Z2) && xy_ok;
  assign code_err_o = (st_q == ST_Z2) && !xy_ok;
  assign code_h_o   = data_i[4];
  assign code_v_o   = data_i[5];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= ST_IDLE;
      phase_q <= 1'b0;
      hbl_q   <= 1'b0;
      vbl_q   <= 1'b0;
    end else begin
      st_q    <= st_d;
      phase_q <= phase_d;
      if (code_stb_o) begin
        hbl_q <= data_i[4];
        vbl_q <= data_i[5];
      end
    end
  end

  assert_code_slot_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    st_q == ST_Z2 |=> st_q == ST_IDLE);

  assert_bad_code_ignored_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    code_err_o |=> $stable(hbl_q) && $stable(vbl_q));
endmodule

// File: rtl/vse_timing.sv
module vse_timing #(
  parameter int CW = 10
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          code_stb_i,
  input  logic          code_h_i,
  input  logic          code_v_i,
  input  logic [CW-1:0] hfp_i,
  input  logic [CW-1:0] hsw_i,
  input  logic [CW-1:0] hbp_i,
  input  logic [CW-1:0] hact_i,
  input  logic [CW-1:0] vfp_i,
  input  logic [CW-1:0] vsw_i,
  input  logic [CW-1:0] vbp_i,
  input  logic [CW-1:0] vact_i,
  output logic          hs_act_o,
  output logic          vs_act_o,
  output logic          htim_err_o,
  output logic          vtim_err_o
);
  localparam int TW = CW + 4;
  localparam int VW = CW + 3;

  logic [TW-1:0] hcnt_q, hbl_len, line_len, sav_pos, hs_hi;
  logic [VW-1:0] vline_q, vbl_len, vs_hi, v_exp;
  logic          h_lock_q, v_lock_q, vst_q, eav, sav;

  always_comb begin
    eav      = code_stb_i & code_h_i;
    sav      = code_stb_i & !code_h_i;
    hbl_len  = TW'(hfp_i) + TW'(hsw_i) + TW'(hbp_i);
    line_len = hbl_len + TW'(hact_i) + TW'(8);
    sav_pos  = hbl_len + TW'(4);
    hs_hi    = TW'(hfp_i) + TW'(hsw_i);
    vbl_len  = VW'(vfp_i) + VW'(vsw_i) + VW'(vbp_i);
    vs_hi    = VW'(vfp_i) + VW'(vsw_i);
    v_exp    = vst_q ? vbl_len : VW'(vact_i);
  end

  assign htim_err_o = h_lock_q &&
                      ((eav && (hcnt_q + TW'(1)) != line_len) ||
                       (sav && (hcnt_q + TW'(1)) != sav_pos));
  assign vtim_err_o = eav && v_lock_q && (code_v_i != vst_q) &&
                      ((vline_q + VW'(1)) != v_exp);
  assign hs_act_o   = h_lock_q && (hcnt_q >= TW'(hfp_i)) && (hcnt_q < hs_hi);
  assign vs_act_o   = vst_q && (vline_q >= VW'(vfp_i)) && (vline_q < vs_hi);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hcnt_q   <= '0;
      h_lock_q <= 1'b0;
      vline_q  <= '0;
      vst_q    <= 1'b0;
      v_lock_q <= 1'b0;
    end else begin
      if (eav) begin
        hcnt_q   <= '0;
        h_lock_q <= 1'b1;
      end else if (hcnt_q != '1) begin
        hcnt_q <= hcnt_q + TW'(1);
      end
      if (eav) begin
        if (code_v_i != vst_q) begin
          vst_q    <= code_v_i;
          vline_q  <= '0;
          v_lock_q <= 1'b1;
        end else if (vline_q != '1) begin
          vline_q <= vline_q + VW'(1);
        end
      end
    end
  end

  assert_line_restart_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eav |=> hcnt_q == '0 && h_lock_q);
endmodule

// File: rtl/vse_flags.sv
module vse_flags #(
  parameter int N = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] flag_o
);
  for (genvar i = 0; i < N; i++) begin : g_flag
    logic flag_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) flag_q <= 1'b0;
      else         flag_q <= set_i[i] | (flag_q & ~clr_i[i]);
    end
    assign flag_o[i] = flag_q;

    assert_flag_sticky_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      flag_q && !clr_i[i] |=> flag_q);
    assert_flag_clear_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      clr_i[i] && !set_i[i] |=> !flag_q);
  end
endmodule

// File: rtl/video_sync_extract.sv
module video_sync_extract
  import vse_pkg::*;
#(
  parameter int CW = 10
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [7:0]    data_i,
  input  logic          hs_pol_i,
  input  logic          vs_pol_i,
  input  logic [CW-1:0] hfp_i,
  input  logic [CW-1:0] hsw_i,
  input  logic [CW-1:0] hbp_i,
  input  logic [CW-1:0] hact_i,
  input  logic [CW-1:0] vfp_i,
  input  logic [CW-1:0] vsw_i,
  input  logic [CW-1:0] vbp_i,
  input  logic [CW-1:0] vact_i,
  input  logic [3:0]    clr_i,
  output logic          hs_o,
  output logic          vs_o,
  output logic [3:0]    err_o,
  output logic          cfg_err_o
);
  logic             code_stb, code_h, code_v, code_err, fill_err;
  logic             hs_act, vs_act, htim_err, vtim_err;
  logic [N_ERR-1:0] err_set;

  vse_code_det u_det (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .data_i     (data_i),
    .code_stb_o (code_stb),
    .code_h_o   (code_h),
    .code_v_o   (code_v),
    .code_err_o (code_err),
    .fill_err_o (fill_err)
  );

  vse_timing #(.CW(CW)) u_tim (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .code_stb_i (code_stb),
    .code_h_i   (code_h),
    .code_v_i   (code_v),
    .hfp_i      (hfp_i),
    .hsw_i      (hsw_i),
    .hbp_i      (hbp_i),
    .hact_i     (hact_i),
    .vfp_i      (vfp_i),
    .vsw_i      (vsw_i),
    .vbp_i      (vbp_i),
    .vact_i     (vact_i),
    .hs_act_o   (hs_act),
    .vs_act_o   (vs_act),
    .htim_err_o (htim_err),
    .vtim_err_o (vtim_err)
  );

  always_comb begin
    err_set           = '0;
    err_set[ERR_CODE] = code_err;
    err_set[ERR_FILL] = fill_err;
    err_set[ERR_HTIM] = htim_err;
    err_set[ERR_VTIM] = vtim_err;
  end

  vse_flags #(.N(N_ERR)) u_flags (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  (err_set),
    .clr_i  (clr_i),
    .flag_o (err_o)
  );

  assign hs_o      = ~(hs_act ^ hs_pol_i);
  assign vs_o      = ~(vs_act ^ vs_pol_i);
  assign cfg_err_o = (hsw_i == '0) || (hact_i == '0) || (vsw_i == '0) || (vact_i == '0);
endmodule

// File: tb/video_sync_extract_bench.sv
`timescale 1ns/100ps
module video_sync_extract_bench;
  localparam int CW = 10;
  localparam int HFP = 2, HSW = 3, HBP = 1, HACT = 6;
  localparam int VFP = 1, VSW = 2, VBP = 1, VACT = 3;
  localparam int HBL = HFP + HSW + HBP;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic [7:0]    data_i = 8'h00;
  logic          hs_pol_i = 1'b1, vs_pol_i = 1'b1;
  logic [CW-1:0] hfp_i, hsw_i, hbp_i, hact_i, vfp_i, vsw_i, vbp_i, vact_i;
  logic [3:0]    clr_i = 4'h0, clr_req = 4'h0;
  logic          hs_o, vs_o, cfg_err_o;
  logic [3:0]    err_o;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  always #2 clk_i = ~clk_i;

  video_sync_extract #(.CW(CW)) u_video_sync_extract (
    .clk_i(clk_i), .rst_ni(rst_ni), .data_i(data_i),
    .hs_pol_i(hs_pol_i), .vs_pol_i(vs_pol_i),
    .hfp_i(hfp_i), .hsw_i(hsw_i), .hbp_i(hbp_i), .hact_i(hact_i),
    .vfp_i(vfp_i), .vsw_i(vsw_i), .vbp_i(vbp_i), .vact_i(vact_i),
    .clr_i(clr_i), .hs_o(hs_o), .vs_o(vs_o), .err_o(err_o), .cfg_err_o(cfg_err_o)
  );

  task automatic check(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic set_cfg();
    hfp_i = CW'(HFP); hsw_i = CW'(HSW); hbp_i = CW'(HBP); hact_i = CW'(HACT);
    vfp_i = CW'(VFP); vsw_i = CW'(VSW); vbp_i = CW'(VBP); vact_i = CW'(VACT);
  endtask

  task automatic put(input logic [7:0] b);
    @(posedge clk_i);
    #1;
    data_i  = b;
    clr_i   = clr_req;
    clr_req = 4'h0;
    @(negedge clk_i);
  endtask

  function automatic logic [7:0] xy(input logic f, input logic v, input logic h);
    return {1'b1, f, v, h, v ^ h, f ^ h, f ^ v, f ^ v ^ h};
  endfunction

  task automatic send_code(input logic [7:0] x);
    put(8'hFF); put(8'h00); put(8'h00); put(x);
  endtask

  // hc: clocks since the line-start code was captured
  task automatic sync_chk(input int hc, input bit vexp);
    bit hact;
    hact = (hc >= HFP) && (hc < HFP + HSW);
    check("R7 hsync", int'(hs_o), int'(hs_pol_i ? hact : !hact));
    check("R8 vsync", int'(vs_o), int'(vs_pol_i ? vexp : !vexp));
  endtask

  // mode: 0 clean, 1 bad protection code, 2 bit7 clear code, 3 extra pixel, 5 fill fault
  task automatic send_line(input bit v, input bit f, input int j, input int mode);
    bit vexp;
    int na;
    logic [7:0] b, badc;
    vexp = v && (j >= VFP) && (j < VFP + VSW);
    send_code(xy(f, v, 1'b1));
    for (int k = 0; k < HBL; k++) begin
      b = (k % 2 == 1) ? 8'h10 : 8'h80;
      if (mode == 5 && k == 1) b = 8'h80;
      put(b);
      sync_chk(k, vexp);
    end
    send_code(xy(f, v, 1'b0));
    na = HACT + ((mode == 3) ? 1 : 0);
    badc = (mode == 2) ? (xy(f, 1'b0, 1'b1) & 8'h7F) : (xy(f, 1'b0, 1'b1) ^ 8'h01);
    for (int k = 0; k < na; k++) begin
      if (v) b = (k % 2 == 1) ? 8'h10 : 8'h80;
      else   b = 8'((k * 37 + j * 11) % 200 + 16);
      if ((mode == 1 || mode == 2) && k < 4)
        b = (k == 0) ? 8'hFF : (k == 3) ? badc : 8'h00;
      put(b);
      sync_chk(HBL + 4 + k, vexp);
    end
  endtask

  task automatic send_frame(input int mode, input bit f);
    for (int j = 0; j < VFP + VSW + VBP; j++)
      send_line(1'b1, f, j, (mode == 5 && j == 0) ? 5 : 0);
    for (int j = 0; j < VACT + ((mode == 4) ? 1 : 0); j++)
      send_line(1'b0, f, j, (j == 1 && mode >= 1 && mode <= 3) ? mode : 0);
  endtask

  initial begin
    int modes [5] = '{1, 2, 3, 5, 4};
    int expv  [5] = '{1, 1, 4, 2, 8};
    set_cfg();
    repeat (3) @(posedge clk_i);
    @(negedge clk_i);
    check("R11 reset flags", int'(err_o), 0);
    check("R11 reset hsync inactive", int'(hs_o), 0);
    check("R11 reset vsync inactive", int'(vs_o), 0);
    check("R9 valid config", int'(cfg_err_o), 0);
    @(posedge clk_i); #1 rst_ni = 1'b1;

    // polarity sweep; F toggles between frames and must not matter (R1)
    for (int p = 0; p < 4; p++) begin
      hs_pol_i = p[0];
      vs_pol_i = p[1];
      send_frame(0, p[0]);
      check("R1 R3 R4 R5 R6 clean frame no flags", int'(err_o), 0);
    end
    send_frame(0, 1'b1);
    check("R1 F ignored, no flags", int'(err_o), 0);

    for (int m = 0; m < 5; m++) begin
      send_frame(modes[m], 1'b0);
      send_frame(0, 1'b1);
      case (modes[m])
        1: check("R2 protection mismatch flagged, no fill fault R4", int'(err_o), expv[m]);
        2: check("R2 bit7 clear flagged", int'(err_o), expv[m]);
        3: check("R5 line length mismatch", int'(err_o), expv[m]);
        5: check("R3 fill pattern fault", int'(err_o), expv[m]);
        default: check("R6 active line count mismatch", int'(err_o), expv[m]);
      endcase
      clr_req = ~4'(expv[m]);
      send_frame(0, 1'b0);
      check("R10 other clear bits keep flag", int'(err_o), expv[m]);
      clr_req = 4'(expv[m]);
      send_frame(0, 1'b0);
      check("R10 write one clears flag", int'(err_o), 0);
    end

    send_frame(5, 1'b0);
    check("R3 fill fault before reset", int'(err_o), 2);
    @(negedge clk_i);
    rst_ni = 1'b0;
    #1;
    check("R11 async reset clears flags", int'(err_o), 0);
    check("R11 async reset hsync inactive", int'(hs_o), hs_pol_i ? 0 : 1);
    check("R11 async reset vsync inactive", int'(vs_o), vs_pol_i ? 0 : 1);
    @(posedge clk_i); #1 rst_ni = 1'b1;
    send_frame(0, 1'b0);
    check("R11 relock after reset, no flags", int'(err_o), 0);

    for (int i = 0; i < 8; i++) begin
      set_cfg();
      case (i)
        0: hfp_i = '0;  1: hsw_i = '0;  2: hbp_i = '0;  3: hact_i = '0;
        4: vfp_i = '0;  5: vsw_i = '0;  6: vbp_i = '0;  default: vact_i = '0;
      endcase
      #1;
      check("R9 zero field config fault", int'(cfg_err_o),
            (i == 1 || i == 3 || i == 5 || i == 7) ? 1 : 0);
    end
    set_cfg();

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk_i);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog R11 actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule